// File: doc/BRIEF.md
# Trace Identifier Message Interpreter

This block takes the one trace byte that arrives with each frame and builds the repeating trace message from it. The message is 1, 16 or 64 bytes long. The block finds message boundaries in the byte stream. It accepts a message once the same message has arrived a programmable number of times in a row. It compares the accepted message with an expected message that the host programs, and it reports two conditions: a mismatch when the accepted and expected messages differ, and instability when successive messages keep changing. Each condition has a latched change flag, which the host clears by writing one to it, and an interrupt mask.

The accepted message is held in a 64-entry register array, and the host can read any entry by address. The expected message is written through a simple write port. A register bus wrapper, which is not part of this block, connects these ports to the host.

Top module: `trace_id_monitor`

## Requirements
- R1: `len_mode` selects the message length. The value 0 selects 1 byte, 1 selects 16 bytes, and 2 or 3 selects 64 bytes. Every byte received with `frm_stb` high goes to the write index of the current message. A message period ends when the byte at the last index (length−1) is written.
- R2: In 16-byte mode, a byte with bit 7 set is written at index 0. Any other byte goes to the index after the previous byte.
- R3: In 64-byte mode, a 0x0A byte that directly follows a 0x0D byte is written at index 63. Any other byte goes to the index after the previous byte.
- R4: A message period is "identical" if no byte written in it differs from the byte last stored at that index. Otherwise it is "changed". When the run of consecutive identical periods, counting the first period after a change as 1, reaches `acc_thr`, the stored message is copied into the accepted array. An `acc_thr` of 0 acts as 1.
- R5: `rd_data` shows the accepted-array entry at `rd_addr` in the same cycle. All entries are 0 after reset.
- R6: `mismatch` is updated one clock after the accepted or expected array changes. It is 1 when a message has been accepted since reset and any of the first length entries of the accepted and expected arrays differ. Otherwise it is 0.
- R7: `unstable` is set at the end of a changed period once the number of consecutive changed periods reaches `unst_thr` (0 acts as 1). It is cleared at the end of an identical period. It changes at no other time.
- R8: `irq_stat[0]` is set when `mismatch` changes, and `irq_stat[1]` is set when `unstable` changes. A 1 in the matching bit of `irq_clr` clears the flag. If a set and a clear happen in the same cycle, the set wins.
- R9: `irq` is high when any bit of `irq_stat` is set and the matching `irq_mask` bit is 0.
- R10: When `len_mode` differs from its value in the previous cycle, the block discards the byte offered in that cycle and resets the alignment, the run counts and the changed-byte flag.
- R11: After reset, `mismatch`, `unstable`, `irq_stat` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_stb | input | 1 | Trace byte valid, one per frame |
| trc_byte | input | 8 | Received trace byte |
| len_mode | input | 2 | Message length select |
| acc_thr | input | 4 | Identical periods needed to accept |
| unst_thr | input | 4 | Changed periods needed to flag instability |
| exp_we | input | 1 | Expected message write enable |
| exp_addr | input | 6 | Expected message write index |
| exp_wdata | input | 8 | Expected message write byte |
| rd_addr | input | 6 | Accepted message read index |
| rd_data | output | 8 | Accepted message byte at rd_addr |
| irq_mask | input | 2 | Interrupt masks, bit0 mismatch, bit1 unstable |
| irq_clr | input | 2 | Write-one-to-clear for irq_stat |
| mismatch | output | 1 | Accepted differs from expected |
| unstable | output | 1 | Incoming message unstable |
| irq_stat | output | 2 | Latched status-change flags |
| irq | output | 1 | Unmasked interrupt request |

## Verification
Assertions check three things on every cycle. A change of `mismatch` or `unstable` latches its flag in the same cycle. A latched flag stays set until it is cleared. `unstable` moves only after a received byte. Assertions cannot show boundary finding from the marker byte or the CR/LF pair, acceptance after exactly the threshold count, or the discard and restart on a length change. The bench shows these with misaligned lead-in bytes, threshold runs and length changes, and it checks all outputs against a behavioural model on every clock.

// File: rtl/trace_id_pkg.sv
// Shared constants and helpers for the trace identifier interpreter.
// Assumes message storage is at least 64 entries deep.
package trace_id_pkg;
    localparam logic [7:0] TRC_CR = 8'h0D;
    localparam logic [7:0] TRC_LF = 8'h0A;

    // Length in bytes for a given length-select code.
    function automatic int msg_len(input logic [1:0] mode);
        case (mode)
            2'd0:    return 1;
            2'd1:    return 16;
            default: return 64;
        endcase
    endfunction
endpackage

// File: rtl/trace_align.sv
// Message alignment: picks the write index for each received byte and
// flags the byte that closes a message period.
// Assumes DEPTH >= 64; len_chg takes priority over stb.
module trace_align
    import trace_id_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [7:0]       din,
    input  logic [1:0]       len_mode,
    input  logic             len_chg,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    logic [IDX_W-1:0] wp;
    logic             prev_cr;
    logic [IDX_W-1:0] last;

    // Choose write index from mode and boundary markers.
    always_comb begin
        last = IDX_W'(msg_len(len_mode) - 1);
        if (len_mode == 2'd0)
            idx = '0;
        else if (len_mode == 2'd1)
            idx = din[7] ? '0 : wp;
        else
            idx = (prev_cr && din == TRC_LF) ? last : wp;
        done = (idx == last);
    end

    // Advance the write pointer and remember a preceding CR.
    always_ff @(posedge clk) begin
        if (!rst_n || len_chg) begin
            wp      <= '0;
            prev_cr <= 1'b0;
        end else if (stb) begin
            wp      <= done ? '0 : idx + 1'b1;
            prev_cr <= (din == TRC_CR);
        end
    end
endmodule

// File: rtl/trace_store.sv
// Storage: last-received bytes, accepted message and expected message.
// Detects changed bytes within a period and compares accepted vs expected.
module trace_store
    import trace_id_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [7:0]       din,
    input  logic [IDX_W-1:0] idx,
    input  logic             done,
    input  logic             len_chg,
    input  logic [1:0]       len_mode,
    input  logic             acc_load,
    input  logic             exp_we,
    input  logic [IDX_W-1:0] exp_addr,
    input  logic [7:0]       exp_wdata,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic             msg_diff,
    output logic             mism
);
    logic [7:0]       cand [DEPTH];
    logic [7:0]       acc  [DEPTH];
    logic [7:0]       expm [DEPTH];
    logic [DEPTH-1:0] neq;
    logic             dirty;

    assign msg_diff = dirty | (cand[idx] != din);
    assign rd_data  = acc[rd_addr];
    assign mism     = |neq;

    // Track whether any byte of the current period changed.
    always_ff @(posedge clk) begin
        if (!rst_n || len_chg) dirty <= 1'b0;
        else if (stb)          dirty <= done ? 1'b0 : msg_diff;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Latest received byte per index.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 cand[g] <= '0;
            else if (stb && idx == IDX_W'(g))           cand[g] <= din;
        end
        // Accepted copy, including the byte closing this period.
        always_ff @(posedge clk) begin
            if (!rst_n)        acc[g] <= '0;
            else if (acc_load) acc[g] <= (idx == IDX_W'(g)) ? din : cand[g];
        end
        // Host-programmed expected byte.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 expm[g] <= '0;
            else if (exp_we && exp_addr == IDX_W'(g))   expm[g] <= exp_wdata;
        end
        assign neq[g] = (g < msg_len(len_mode)) && (acc[g] != expm[g]);
    end
endmodule

// File: rtl/trace_status.sv
// Run counters, accept decision, mismatch/unstable flags and interrupts.
module trace_status #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             done,
    input  logic             msg_diff,
    input  logic             len_chg,
    input  logic             mism,
    input  logic [CNT_W-1:0] acc_thr,
    input  logic [CNT_W-1:0] unst_thr,
    input  logic [1:0]       irq_mask,
    input  logic [1:0]       irq_clr,
    output logic             acc_load,
    output logic             mismatch,
    output logic             unstable,
    output logic [1:0]       irq_stat,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] run, chg, run_n, chg_n, eff_acc, eff_unst;
    logic             acc_valid, end_p, tim_n, tiu_n;

    // Next counter values and flag decisions at a period end.
    always_comb begin
        end_p    = stb && done;
        eff_acc  = (acc_thr == '0) ? ONE : acc_thr;
        eff_unst = (unst_thr == '0) ? ONE : unst_thr;
        run_n    = msg_diff ? ONE : ((run == CMAX) ? run : run + 1'b1);
        chg_n    = msg_diff ? ((chg == CMAX) ? chg : chg + 1'b1) : '0;
        acc_load = end_p && (run_n == eff_acc);
        tim_n    = acc_valid && mism;
        tiu_n    = unstable;
        if (end_p) begin
            if (!msg_diff)              tiu_n = 1'b0;
            else if (chg_n >= eff_unst) tiu_n = 1'b1;
        end
    end

    // Counter state, cleared on reset or a length change.
    always_ff @(posedge clk) begin
        if (!rst_n || len_chg) begin
            run <= '0;
            chg <= '0;
        end else if (end_p) begin
            run <= run_n;
            chg <= chg_n;
        end
    end

    // Status flags and latched change bits (set beats clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_valid <= 1'b0;
            mismatch  <= 1'b0;
            unstable  <= 1'b0;
            irq_stat  <= '0;
        end else begin
            acc_valid   <= acc_valid | acc_load;
            mismatch    <= tim_n;
            unstable    <= tiu_n;
            irq_stat[0] <= (irq_stat[0] & ~irq_clr[0]) | (tim_n != mismatch);
            irq_stat[1] <= (irq_stat[1] & ~irq_clr[1]) | (tiu_n != unstable);
        end
    end

    assign irq = |(irq_stat & ~irq_mask);
endmodule

// File: rtl/trace_id_monitor.sv
// Top of the trace identifier interpreter. Detects a length-select change
// and wires alignment, storage and status together.
module trace_id_monitor #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_stb,
    input  logic [7:0]       trc_byte,
    input  logic [1:0]       len_mode,
    input  logic [CNT_W-1:0] acc_thr,
    input  logic [CNT_W-1:0] unst_thr,
    input  logic             exp_we,
    input  logic [IDX_W-1:0] exp_addr,
    input  logic [7:0]       exp_wdata,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    input  logic [1:0]       irq_mask,
    input  logic [1:0]       irq_clr,
    output logic             mismatch,
    output logic             unstable,
    output logic [1:0]       irq_stat,
    output logic             irq
);
    logic [1:0]       len_q;
    logic             len_chg, stb_eff, done, msg_diff, mism, acc_load;
    logic [IDX_W-1:0] idx;

    // Remember the previous length select.
    always_ff @(posedge clk) begin
        if (!rst_n) len_q <= 2'd0;
        else        len_q <= len_mode;
    end

    assign len_chg = (len_mode != len_q);
    assign stb_eff = frm_stb && !len_chg;

    trace_align #(.DEPTH(DEPTH)) u_align (
        .clk(clk), .rst_n(rst_n), .stb(stb_eff), .din(trc_byte),
        .len_mode(len_mode), .len_chg(len_chg), .idx(idx), .done(done)
    );

    trace_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .stb(stb_eff), .din(trc_byte),
        .idx(idx), .done(done), .len_chg(len_chg), .len_mode(len_mode),
        .acc_load(acc_load), .exp_we(exp_we), .exp_addr(exp_addr),
        .exp_wdata(exp_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .msg_diff(msg_diff), .mism(mism)
    );

    trace_status #(.CNT_W(CNT_W)) u_status (
        .clk(clk), .rst_n(rst_n), .stb(stb_eff), .done(done),
        .msg_diff(msg_diff), .len_chg(len_chg), .mism(mism),
        .acc_thr(acc_thr), .unst_thr(unst_thr), .irq_mask(irq_mask),
        .irq_clr(irq_clr), .acc_load(acc_load), .mismatch(mismatch),
        .unstable(unstable), .irq_stat(irq_stat), .irq(irq)
    );
endmodule

// File: rtl/trace_id_monitor_chk.sv
// Port-level checker for trace_id_monitor, attached by bind below.
module trace_id_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_stb,
    input logic       mismatch,
    input logic       unstable,
    input logic [1:0] irq_stat,
    input logic [1:0] irq_clr,
    input logic [1:0] irq_mask,
    input logic       irq
);
    AST_TIM_CHG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch != $past(mismatch)) |-> irq_stat[0]); // R8
    AST_TIU_CHG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (unstable != $past(unstable)) |-> irq_stat[1]); // R8
    AST_TIM_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat[0] && !irq_clr[0]) |=> irq_stat[0]); // R8
    AST_TIU_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat[1] && !irq_clr[1]) |=> irq_stat[1]); // R8
    AST_TIU_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frm_stb) |-> $stable(unstable)); // R7
    AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == 2'b11) |-> !irq); // R9
endmodule

bind trace_id_monitor trace_id_monitor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .mismatch(mismatch),
    .unstable(unstable), .irq_stat(irq_stat), .irq_clr(irq_clr),
    .irq_mask(irq_mask), .irq(irq)
);

// File: tb/tb_trace_id_monitor.sv
`timescale 1ns/1ps
module tb_trace_id_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_stb = 1'b0;
    logic [7:0] trc_byte = '0;
    logic [1:0] len_mode = '0;
    logic [3:0] acc_thr = 4'd3;
    logic [3:0] unst_thr = 4'd15;
    logic       exp_we = 1'b0;
    logic [5:0] exp_addr = '0;
    logic [7:0] exp_wdata = '0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] irq_mask = '0;
    logic [1:0] irq_clr = '0;
    logic       mismatch, unstable, irq;
    logic [1:0] irq_stat;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    trace_id_monitor dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_cand [64];
    logic [7:0] m_acc  [64];
    logic [7:0] m_exp  [64];
    int m_wp, m_run, m_chg;
    bit m_prevcr, m_dirty, m_accv, m_tim, m_tiu;
    logic [1:0] m_stat, m_lenq;

    function automatic int lenof(input logic [1:0] m);
        return (m == 0) ? 1 : (m == 1) ? 16 : 64;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) begin
                m_cand[i] = 0; m_acc[i] = 0; m_exp[i] = 0;
            end
            m_wp = 0; m_run = 0; m_chg = 0; m_prevcr = 0; m_dirty = 0;
            m_accv = 0; m_tim = 0; m_tiu = 0; m_stat = 0; m_lenq = 0;
        end else begin
            int  L, ix, ea, eu;
            bit  mm, tn, un, dn, d, ld;
            L  = lenof(len_mode);
            mm = 0;
            for (int i = 0; i < L; i++) if (m_acc[i] != m_exp[i]) mm = 1;
            tn = m_accv && mm;
            un = m_tiu;
            if (len_mode != m_lenq) begin
                m_wp = 0; m_prevcr = 0; m_dirty = 0; m_run = 0; m_chg = 0;
            end else if (frm_stb) begin
                if (L == 1) ix = 0;
                else if (L == 16) ix = trc_byte[7] ? 0 : m_wp;
                else ix = (m_prevcr && trc_byte == 8'h0A) ? 63 : m_wp;
                dn = (ix == L - 1);
                d  = m_dirty || (m_cand[ix] != trc_byte);
                ea = (acc_thr == 0) ? 1 : acc_thr;
                eu = (unst_thr == 0) ? 1 : unst_thr;
                ld = 0;
                if (dn) begin
                    if (d) begin
                        m_run = 1;
                        if (m_chg < 15) m_chg++;
                        if (m_chg >= eu) un = 1;
                    end else begin
                        if (m_run < 15) m_run++;
                        m_chg = 0;
                        un = 0;
                    end
                    ld = (m_run == ea);
                end
                m_cand[ix] = trc_byte;
                if (ld) begin
                    for (int i = 0; i < 64; i++) m_acc[i] = m_cand[i];
                    m_accv = 1;
                end
                m_dirty  = dn ? 0 : d;
                m_wp     = dn ? 0 : ix + 1;
                m_prevcr = (trc_byte == 8'h0D);
            end
            if (exp_we) m_exp[exp_addr] = exp_wdata;
            m_stat[0] = (m_stat[0] & ~irq_clr[0]) | (tn != m_tim);
            m_stat[1] = (m_stat[1] & ~irq_clr[1]) | (un != m_tiu);
            m_tim  = tn;
            m_tiu  = un;
            m_lenq = len_mode;
        end
        #1;
        chk("R6 mismatch", {31'b0, mismatch}, {31'b0, m_tim});
        chk("R7 unstable", {31'b0, unstable}, {31'b0, m_tiu});
        chk("R8 irq_stat", {30'b0, irq_stat}, {30'b0, m_stat});
        chk("R9 irq", {31'b0, irq}, {31'b0, |(m_stat & ~irq_mask)});
        chk("R5 rd_data", {24'b0, rd_data}, {24'b0, m_acc[rd_addr]});
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(input logic [7:0] b);
        @(negedge clk); frm_stb = 1'b1; trc_byte = b;
        @(negedge clk); frm_stb = 1'b0;
    endtask

    task automatic wexp(input int a, input logic [7:0] d);
        @(negedge clk); exp_we = 1'b1; exp_addr = 6'(a); exp_wdata = d;
        @(negedge clk); exp_we = 1'b0;
    endtask

    function automatic logic [7:0] m16(input int i);
        return (i == 0) ? 8'h95 : 8'(8'h30 + i);
    endfunction

    function automatic logic [7:0] m64(input int i);
        return (i == 62) ? 8'h0D : (i == 63) ? 8'h0A : 8'(8'h40 + i);
    endfunction

    task automatic run_test();
        repeat (3) @(negedge clk);
        chk("R11 mismatch reset", {31'b0, mismatch}, 0);
        chk("R11 unstable reset", {31'b0, unstable}, 0);
        chk("R11 irq_stat reset", {30'b0, irq_stat}, 0);
        chk("R11 irq reset", {31'b0, irq}, 0);
        rst_n = 1'b1;

        // 1-byte mode, accept after three identical bytes
        wexp(0, 8'h41);
        send(8'h41); send(8'h41);
        chk("R4 not yet accepted", {24'b0, rd_data}, 0);
        send(8'h41);
        chk("R4 R1 accepted at threshold", {24'b0, rd_data}, 32'h41);
        @(negedge clk);
        chk("R6 match expected", {31'b0, mismatch}, 0);
        repeat (3) send(8'h42);
        @(negedge clk);
        chk("R5 accepted byte read", {24'b0, rd_data}, 32'h42);
        chk("R6 mismatch set", {31'b0, mismatch}, 1);
        chk("R8 mismatch change latched", {31'b0, irq_stat[0]}, 1);
        chk("R9 irq unmasked", {31'b0, irq}, 1);
        irq_mask = 2'b01; #1;
        chk("R9 irq masked", {31'b0, irq}, 0);
        @(negedge clk); irq_clr = 2'b01;
        @(negedge clk); irq_clr = 2'b00;
        chk("R8 write-one-to-clear", {31'b0, irq_stat[0]}, 0);
        irq_mask = 2'b00;

        // instability
        unst_thr = 4'd3;
        send(8'h01); send(8'h02);
        chk("R7 below unstable count", {31'b0, unstable}, 0);
        send(8'h03);
        chk("R7 unstable at count", {31'b0, unstable}, 1);
        chk("R8 unstable change latched", {31'b0, irq_stat[1]}, 1);
        send(8'h03);
        chk("R7 cleared by identical period", {31'b0, unstable}, 0);

        // zero accept threshold acts as one
        acc_thr = 4'd0;
        send(8'h07);
        chk("R4 zero threshold accepts at once", {24'b0, rd_data}, 32'h07);

        // length change resets the run count
        acc_thr = 4'd3;
        send(8'h05); send(8'h05);
        @(negedge clk); len_mode = 2'd1;
        @(negedge clk); len_mode = 2'd0;
        @(negedge clk);
        send(8'h05);
        chk("R10 run restarted after length change", {24'b0, rd_data}, 32'h07);
        send(8'h05); send(8'h05);
        chk("R10 accepted after full new run", {24'b0, rd_data}, 32'h05);

        // 16-byte mode with misaligned lead-in; discarded byte on change
        acc_thr = 4'd2;
        @(negedge clk); len_mode = 2'd1; frm_stb = 1'b1; trc_byte = 8'hFF;
        @(negedge clk); frm_stb = 1'b0;
        for (int i = 0; i < 16; i++) wexp(i, m16(i));
        for (int i = 0; i < 5; i++) send(8'(8'h61 + i));
        for (int i = 0; i < 16; i++) send(m16(i));
        chk("R2 one period not enough", {24'b0, rd_data}, 32'h05);
        for (int i = 0; i < 16; i++) send(m16(i));
        chk("R2 marker at index 0", {24'b0, rd_data}, 32'h95);
        rd_addr = 6'd15; #1;
        chk("R2 last byte at index 15", {24'b0, rd_data}, 32'h3F);
        @(negedge clk);
        chk("R6 16-byte match", {31'b0, mismatch}, 0);

        // 64-byte mode aligned by CR/LF
        rd_addr = 6'd0;
        @(negedge clk); len_mode = 2'd2;
        @(negedge clk);
        for (int i = 0; i < 10; i++) send(8'h20);
        for (int k = 0; k < 3; k++)
            for (int i = 0; i < 64; i++) send(m64(i));
        chk("R3 first byte at index 0", {24'b0, rd_data}, 32'h40);
        rd_addr = 6'd63; #1;
        chk("R3 LF at index 63", {24'b0, rd_data}, 32'h0A);
        rd_addr = 6'd62; #1;
        chk("R3 CR at index 62", {24'b0, rd_data}, 32'h0D);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            run_test();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule